// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer N = B·P + A, the job of the feedback divider in a synthesizer loop. A dual-modulus prescaler counts P or P+1 input cycles per output tick. A 6-bit swallow counter keeps the prescaler in its long modulus for the first A ticks of each output period. An 11-bit main counter ends the period after B ticks. A 14-bit reference counter divides a separate reference clock by R. Together these give the two edges a phase comparator would use.

The block holds `N_CH` independent channels, two by default. Each channel has its own A, B, R and modulus choice. All channels share one fast clock and one reference clock. Each channel produces a one-cycle pulse per divided period in each clock domain. A channel whose A/B setting is illegal raises a flag and keeps its divided pulse quiet.

Settings are loaded into the working counters only at the end of a divided period. A setting written at any time therefore never shortens or stretches the period already in progress.

Top module: `pswallow_divider`

## Requirements
- R1: With a legal setting, `div_pulse` of a channel is high for exactly one `rf_clk` cycle, and successive rising pulses are B·P + A cycles apart.
- R2: `mode_sel` bit 0 for a channel selects P = 32 (prescaler divides by 32 or 33); bit 1 selects P = 64 (divides by 64 or 65).
- R3: A is the 6-bit field `a_val[c*6 +: 6]` and B is the 11-bit field `b_val[c*11 +: 11]`. Every A from 0 up to B is honoured, including A = 0 and A = B = 63.
- R4: A setting with B < A or B < 3 sets `cfg_bad` for that channel once it is loaded, and no `div_pulse` occurs while it stays loaded. After a legal setting is written, the flag clears and pulses resume within one prescaler period plus one divided period.
- R5: New A, B or mode values written during a divided period take effect only when that period ends. The period in progress keeps its old length.
- R6: For R ≥ 2 in the 14-bit field `r_val[c*14 +: 14]`, `ref_pulse` is high for one `ref_clk` cycle every R cycles.
- R7: R = 0 and R = 1 both divide by one: `ref_pulse` stays high on every `ref_clk` cycle.
- R8: A new R takes effect only at the next `ref_pulse` boundary. The reference period in progress keeps its old length.
- R9: Each channel's outputs depend only on its own settings. Changing or invalidating one channel leaves the other channel's periods and flag unchanged.
- R10: While `rst` is high, synchronous to each clock, `div_pulse` and `ref_pulse` are low, and `cfg_bad` shows whether the settings on the inputs are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| rf_clk | input | 1 | Fast clock to be divided by N |
| ref_clk | input | 1 | Reference clock to be divided by R |
| mode_sel | input | N_CH | Per-channel prescaler pair: 0 = 32/33, 1 = 64/65 |
| a_val | input | N_CH*6 | Per-channel swallow count A |
| b_val | input | N_CH*11 | Per-channel main count B |
| r_val | input | N_CH*14 | Per-channel reference divide R |
| div_pulse | output | N_CH | One-cycle pulse per divided fast-clock period |
| ref_pulse | output | N_CH | One-cycle pulse per divided reference period |
| cfg_bad | output | N_CH | Loaded A/B setting is illegal |

## Verification
A wrong swallow or main count shows up as a pulse spacing off by a multiple of one cycle or of P. That error is visible at the second `div_pulse` after the setting is loaded, so the bench measures the exact gap across a sweep of A, B and both moduli. A setting applied too early shows as a shortened gap that straddles the change, so the gap across each change is checked against the old N. The reference side is checked the same way, and its divide-by-one case is checked as a pulse that never drops. A leaked pulse or a stale flag on an illegal setting shows within one prescaler period, and the bench watches for it over a window longer than any legal period in use.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } pmod_e;

  // Legal when the swallow count never exceeds the main count and B >= 3.
  function automatic logic cfg_ok(input int unsigned a, input int unsigned b);
    return (b >= a) && (b >= 32'd3);
  endfunction

endpackage

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
  parameter int PLO_LOG2 = 5,
  parameter int PHI_LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_sel,
  input  logic mc_plus,
  output logic tc
);
  import pswd_pkg::*;

  localparam int CW = PHI_LOG2 + 1;
  localparam logic [CW-1:0] PLO = CW'(2 ** PLO_LOG2);
  localparam logic [CW-1:0] PHI = CW'(2 ** PHI_LOG2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_v;
  logic [CW-1:0] base_v;

  always_comb begin
    base_v = (pmod_e'(hi_sel) == MOD_HI) ? PHI : PLO;
    load_v = mc_plus ? base_v : base_v - CW'(1);
  end

  assign tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || tc) cnt <= load_v;
    else           cnt <= cnt - CW'(1);
  end

  // cycles since the last reload, used to bound the prescaler period
  logic [CW-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || tc) gap_q <= '0;
    else           gap_q <= gap_q + CW'(1);
  end

  p_presc_len_r2: assert property (@(posedge clk) disable iff (rst)
    tc |-> (gap_q >= PLO - CW'(1)) && (gap_q <= PHI))
    else $error("prescaler period outside P..P_HI+1");

endmodule

// File: rtl/pswd_swallow_ctl.sv
module pswd_swallow_ctl #(
  parameter int A_W = 6,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hi_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           presc_tc,
  output logic           hi_sel,
  output logic           mc_plus,
  output logic           div_pulse,
  output logic           cfg_bad
);
  import pswd_pkg::*;

  logic [A_W-1:0] a_cnt, a_nx;
  logic [B_W-1:0] b_cnt, b_nx;
  logic           hi_q, hi_nx;
  logic           ok_q, ok_nx;
  logic           end_cyc, load_new;

  always_comb begin
    end_cyc  = presc_tc && (!ok_q || (b_cnt <= B_W'(1)));
    load_new = rst || end_cyc;
    if (load_new) begin
      a_nx  = a_in;
      b_nx  = b_in;
      hi_nx = hi_in;
      ok_nx = cfg_ok(32'(a_in), 32'(b_in));
    end else if (presc_tc) begin
      a_nx  = a_cnt - A_W'(a_cnt != '0);
      b_nx  = b_cnt - B_W'(1);
      hi_nx = hi_q;
      ok_nx = ok_q;
    end else begin
      a_nx  = a_cnt;
      b_nx  = b_cnt;
      hi_nx = hi_q;
      ok_nx = ok_q;
    end
  end

  // modulus for the prescaler cycle that starts after this edge
  assign mc_plus = (a_nx != '0);
  assign hi_sel  = hi_nx;

  always_ff @(posedge clk) begin
    a_cnt     <= a_nx;
    b_cnt     <= b_nx;
    hi_q      <= hi_nx;
    ok_q      <= ok_nx;
    cfg_bad   <= !ok_nx;
    div_pulse <= !rst && end_cyc && ok_q;
  end

  p_pulse_after_tc_r1: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(presc_tc))
    else $error("divided pulse without prescaler terminal count");

  p_swallow_le_main_r3: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (B_W'(a_cnt) <= b_cnt))
    else $error("swallow count exceeds main count");

  p_bad_silent_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> !div_pulse)
    else $error("pulse while illegal setting loaded");

  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(presc_tc)) |-> ($stable(hi_q) && $stable(ok_q)))
    else $error("setting changed inside a prescaler period");

endmodule

// File: rtl/pswd_ref_div.sv
module pswd_ref_div #(
  parameter int R_W = 14
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] r_in,
  output logic           ref_pulse
);

  logic [R_W-1:0] r_cnt;
  logic [R_W-1:0] r_ld;

  assign r_ld = (r_in <= R_W'(1)) ? '0 : r_in - R_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt     <= r_ld;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= (r_cnt == '0);
      r_cnt     <= (r_cnt == '0) ? r_ld : r_cnt - R_W'(1);
    end
  end

  // distance between reference pulses, saturating
  logic [R_W:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || ref_pulse)   gap_q <= '0;
    else if (!(&gap_q))     gap_q <= gap_q + (R_W+1)'(1);
  end

  p_ref_gap_r6: assert property (@(posedge clk) disable iff (rst)
    gap_q < (R_W+1)'(2 ** R_W))
    else $error("reference pulse gap exceeds counter range");

  p_unity_stays_r7: assert property (@(posedge clk) disable iff (rst)
    ((r_cnt == '0) && (r_in <= R_W'(1))) |=> ((r_cnt == '0) && ref_pulse))
    else $error("divide-by-one reference dropped a pulse");

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int N_CH     = 2,
  parameter int A_W      = 6,
  parameter int B_W      = 11,
  parameter int R_W      = 14,
  parameter int PLO_LOG2 = 5,
  parameter int PHI_LOG2 = 6
) (
  input  logic              rst,
  input  logic              rf_clk,
  input  logic              ref_clk,
  input  logic [N_CH-1:0]   mode_sel,
  input  logic [N_CH*A_W-1:0] a_val,
  input  logic [N_CH*B_W-1:0] b_val,
  input  logic [N_CH*R_W-1:0] r_val,
  output logic [N_CH-1:0]   div_pulse,
  output logic [N_CH-1:0]   ref_pulse,
  output logic [N_CH-1:0]   cfg_bad
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hi_sel, mc_plus, presc_tc;

    pswd_prescaler #(
      .PLO_LOG2(PLO_LOG2),
      .PHI_LOG2(PHI_LOG2)
    ) presc_i (
      .clk    (rf_clk),
      .rst    (rst),
      .hi_sel (hi_sel),
      .mc_plus(mc_plus),
      .tc     (presc_tc)
    );

    pswd_swallow_ctl #(
      .A_W(A_W),
      .B_W(B_W)
    ) ctl_i (
      .clk      (rf_clk),
      .rst      (rst),
      .hi_in    (mode_sel[c]),
      .a_in     (a_val[c*A_W +: A_W]),
      .b_in     (b_val[c*B_W +: B_W]),
      .presc_tc (presc_tc),
      .hi_sel   (hi_sel),
      .mc_plus  (mc_plus),
      .div_pulse(div_pulse[c]),
      .cfg_bad  (cfg_bad[c])
    );

    pswd_ref_div #(
      .R_W(R_W)
    ) rdiv_i (
      .clk      (ref_clk),
      .rst      (rst),
      .r_in     (r_val[c*R_W +: R_W]),
      .ref_pulse(ref_pulse[c])
    );
  end

endmodule

// File: tb/pswallow_divider_tb_top.sv
module pswallow_divider_tb_top;

  localparam int TMO = 20000;

  logic        rst = 1'b1;
  logic        rf_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic [11:0] a_val = '0;
  logic [21:0] b_val = '0;
  logic [27:0] r_val = '0;
  logic [1:0]  div_pulse, ref_pulse, cfg_bad;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #10 rf_clk = ~rf_clk;
  initial begin
    #3;
    forever #10 ref_clk = ~ref_clk;
  end

  pswallow_divider dut_i (
    .rst(rst), .rf_clk(rf_clk), .ref_clk(ref_clk),
    .mode_sel(mode_sel), .a_val(a_val), .b_val(b_val), .r_val(r_val),
    .div_pulse(div_pulse), .ref_pulse(ref_pulse), .cfg_bad(cfg_bad)
  );

  always @(posedge rf_clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk = n_chk + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int n_of(input int a, input int b, input int m);
    return b * (m ? 64 : 32) + a;
  endfunction

  task automatic set_div(input int c, input int a, input int b, input int m);
    a_val[c*6 +: 6]   = 6'(a);
    b_val[c*11 +: 11] = 11'(b);
    mode_sel[c]       = 1'(m);
  endtask

  task automatic set_ref(input int c, input int r);
    r_val[c*14 +: 14] = 14'(r);
  endtask

  // Returns at the sample where a pulse is high; g is the gap to the previous one.
  task automatic div_gap(input int c, output int g);
    int t;
    t = 0;
    do begin @(negedge rf_clk); t++; end while (div_pulse[c] && t < TMO);
    while (!div_pulse[c] && t < TMO) begin @(negedge rf_clk); t++; end
    g = 0;
    do begin @(negedge rf_clk); g++; end while (!div_pulse[c] && g < TMO);
  endtask

  // Called at a high sample: writes new settings one cycle later, returns gap.
  task automatic div_gap_change(input int c, input int a, input int b, input int m,
                                output int g);
    g = 0;
    @(negedge rf_clk); g++;
    set_div(c, a, b, m);
    while (!div_pulse[c] && g < TMO) begin @(negedge rf_clk); g++; end
  endtask

  task automatic ref_gap(input int c, output int g);
    int t;
    t = 0;
    do begin @(negedge ref_clk); t++; end while (ref_pulse[c] && t < TMO);
    while (!ref_pulse[c] && t < TMO) begin @(negedge ref_clk); t++; end
    g = 0;
    do begin @(negedge ref_clk); g++; end while (!ref_pulse[c] && g < TMO);
  endtask

  task automatic ref_gap_change(input int c, input int r, output int g);
    g = 0;
    @(negedge ref_clk); g++;
    set_ref(c, r);
    while (!ref_pulse[c] && g < TMO) begin @(negedge ref_clk); g++; end
  endtask

  task automatic count_div(input int c, input int len, output int hits);
    hits = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge rf_clk);
      if (div_pulse[c]) hits++;
    end
  endtask

  initial begin
    int g, h;
    int bl[4] = '{3, 4, 5, 7};

    set_div(0, 1, 3, 0);
    set_div(1, 2, 5, 1);
    set_ref(0, 4);
    set_ref(1, 7);
    rst = 1'b1;
    repeat (6) @(negedge rf_clk);
    // R10: reset state
    chk("R10 div_pulse in reset", int'(div_pulse), 0);
    chk("R10 ref_pulse in reset", int'(ref_pulse), 0);
    chk("R10 cfg_bad in reset",   int'(cfg_bad), 0);
    rst = 1'b0;

    // R1 basic period and pulse width
    div_gap(0, g); chk("R1 period A1 B3 P32", g, n_of(1, 3, 0));
    div_gap(1, g); chk("R9 ch1 own period",   g, n_of(2, 5, 1));

    // R2 / R3 sweep over both moduli and every A in 0..B
    for (int m = 0; m < 2; m++) begin
      foreach (bl[k]) begin
        for (int a = 0; a <= bl[k]; a++) begin
          set_div(0, a, bl[k], m);
          div_gap(0, g);
          chk($sformatf("R2 R3 period a=%0d b=%0d m=%0d", a, bl[k], m), g, n_of(a, bl[k], m));
        end
      end
    end

    // R3 wide values
    set_div(0, 63, 63, 0);
    div_gap(0, g); chk("R3 A=B=63 P32", g, n_of(63, 63, 0));
    set_div(0, 63, 100, 1);
    div_gap(0, g); chk("R3 A63 B100 P64", g, n_of(63, 100, 1));

    // R5 change mid-period keeps old length, then new length
    set_div(0, 3, 5, 0);
    div_gap(0, g); chk("R5 before change", g, n_of(3, 5, 0));
    div_gap_change(0, 1, 4, 1, g); chk("R5 period across change", g, n_of(3, 5, 0));
    div_gap(0, g); chk("R5 new period", g, n_of(1, 4, 1));

    // R4 illegal settings
    set_div(0, 5, 4, 0);
    repeat (600) @(negedge rf_clk);
    chk("R4 flag B<A", int'(cfg_bad[0]), 1);
    count_div(0, 1500, h); chk("R4 silent B<A", h, 0);
    set_div(0, 0, 2, 1);
    repeat (200) @(negedge rf_clk);
    chk("R4 flag B<3", int'(cfg_bad[0]), 1);
    count_div(0, 1500, h); chk("R4 silent B<3", h, 0);
    set_div(0, 0, 3, 0);
    repeat (200) @(negedge rf_clk);
    chk("R4 flag cleared", int'(cfg_bad[0]), 0);
    div_gap(0, g); chk("R4 recovered period", g, n_of(0, 3, 0));

    // R9 independence: invalidate ch1, ch0 keeps running
    set_div(1, 9, 3, 0);
    div_gap(0, g); chk("R9 ch0 period with ch1 bad", g, n_of(0, 3, 0));
    repeat (400) @(negedge rf_clk);
    chk("R9 ch1 flagged", int'(cfg_bad[1]), 1);
    chk("R9 ch0 not flagged", int'(cfg_bad[0]), 0);
    set_div(1, 2, 5, 1);
    repeat (100) @(negedge rf_clk);
    div_gap(1, g); chk("R9 ch1 recovered", g, n_of(2, 5, 1));

    // R6 reference divide
    ref_gap(0, g); chk("R6 ref R=4", g, 4);
    ref_gap(1, g); chk("R9 ref ch1 R=7", g, 7);
    foreach (bl[k]) begin
      set_ref(0, bl[k] * 3 - 1);
      ref_gap(0, g); chk($sformatf("R6 ref R=%0d", bl[k] * 3 - 1), g, bl[k] * 3 - 1);
    end
    set_ref(0, 2);
    ref_gap(0, g); chk("R6 ref R=2", g, 2);
    set_ref(0, 16383);
    ref_gap(0, g); chk("R6 ref R max", g, 16383);

    // R8 change mid-period
    set_ref(0, 6);
    ref_gap(0, g); chk("R8 before change", g, 6);
    ref_gap_change(0, 9, g); chk("R8 period across change", g, 6);
    ref_gap(0, g); chk("R8 new period", g, 9);

    // R7 divide-by-one for R=1 and R=0
    for (int r = 1; r >= 0; r--) begin
      set_ref(0, r);
      repeat (25) @(negedge ref_clk);
      h = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge ref_clk);
        if (ref_pulse[0]) h++;
      end
      chk($sformatf("R7 ref always high R=%0d", r), h, 20);
    end
    set_ref(0, 5);
    ref_gap(0, g); chk("R7 leave unity", g, 5);
    ref_gap(1, g); chk("R9 ref ch1 unchanged", g, 7);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule